// File: doc/BRIEF.md
# Prioritized Interrupt Recognition Controller

This block sits between seven interrupt request lines and a processor core. Each request line is active-low. Level 1 is the lowest priority and level 7 the highest. Every line passes through a reset-safe synchronizer. The block then looks at all pending levels together and selects the highest one that the current priority mask allows. It offers that level to the core as a 3-bit code on a valid/ready channel.

Levels 1 to 6 are level-sensitive. Each is held off while its number is less than or equal to the mask. Level 7 cannot be masked, but it is qualified differently. A high-to-low transition must first be captured in an edge latch, and the line must still be low when the request is recognized. The latch is cleared only when the core accepts a level-7 request, so a line held low is taken once.

The priority mask lives inside the block, and its value is visible on an output. When the core accepts a request, the mask is raised to the accepted level. The core can also write the mask directly, for example when it restores the mask after a handler. If both happen in the same cycle, the acceptance takes priority.

Back-pressure rules:
- While `rec_valid` is high and `rec_ready` is low, `rec_level` may rise if a higher level becomes pending.
- `rec_valid` may fall if a level-sensitive request is withdrawn.
- The core takes whatever level is presented in the cycle where both `rec_valid` and `rec_ready` are high.

Top module: `irq_recognizer`

## Requirements
- R1: After reset, `rec_valid` is 0 and `cur_mask` is 7.
- R2: A request on levels 1 to 6 is presented only when its level is strictly greater than `cur_mask`. A request at a level equal to or below the mask gives `rec_valid` = 0.
- R3: With `cur_mask` = 0, any single request on levels 1 to 6 is presented. `rec_level` carries the level number in binary.
- R4: When several levels are low together, `rec_level` shows the highest unmasked one.
- R5: Level 7 is presented as `rec_level` = 7 even when `cur_mask` = 7.
- R6: After level 7 is accepted, a line that stays low is not presented again. A new high-to-low transition makes it pending once more.
- R7: A level-7 line that falls and rises again before recognition leaves `rec_valid` at 0.
- R8: A handshake (`rec_valid` and `rec_ready` both high) loads `cur_mask` with the accepted level on the next clock.
- R9: `mask_load` writes `mask_value` into `cur_mask` on the next clock. A handshake in the same cycle takes priority over the write.
- R10: A low on levels 1 to 6, set up before a clock edge, shows on the outputs after the second rising edge. A low on level 7 shows after the third rising edge.
- R11: Releasing a level 1 to 6 line removes it from selection. The output falls back to the next pending level, or `rec_valid` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low request lines; bit i is level i+1 |
| mask_load | input | 1 | Write strobe for the priority mask |
| mask_value | input | 3 | Mask value to write |
| cur_mask | output | 3 | Current priority mask |
| rec_valid | output | 1 | A recognized request is offered |
| rec_level | output | 3 | Level of the offered request |
| rec_ready | input | 1 | Core accepts the offered request |

## Verification
The bench builds the block with its default parameters: a 3-bit level code (seven request lines) and two synchronizer stages. With these values, every one of the eight mask values can be reached, including the boundary where the mask equals a request level. The exact two-cycle and three-cycle recognition latencies can be checked cycle by cycle. Both ways of re-arming the non-maskable level can be driven: a real transition, and a glitch that returns high before recognition.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
  localparam int DEF_LVL_W  = 3;
  localparam int DEF_STAGES = 2;

  function automatic int top_level(input int lvl_w);
    return (1 << lvl_w) - 1;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_n,
  output logic [W-1:0] pend
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else if (s == 0) stg[s] <= line_n;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign pend = ~stg[STAGES-1];
endmodule

// File: rtl/nmi_qual.sv
module nmi_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic clr,
  output logic pend
);
  logic prev, armed, fall;

  assign fall = line & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      armed <= 1'b0;
    end else begin
      prev <= line;
      if (fall)     armed <= 1'b1;
      else if (clr) armed <= 1'b0;
    end
  end

  assign pend = armed & line;
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int LVL_W = 3,
  localparam int NLVL = (1 << LVL_W) - 1
) (
  input  logic [NLVL-2:0]  req,
  input  logic             nmi,
  input  logic [LVL_W-1:0] mask,
  output logic             valid,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    valid = 1'b0;
    level = '0;
    for (int i = 0; i < NLVL-1; i++) begin
      if (req[i] && (LVL_W'(i+1) > mask)) begin
        valid = 1'b1;
        level = LVL_W'(i+1);
      end
    end
    if (nmi) begin
      valid = 1'b1;
      level = '1;
    end
  end
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
  import irq_rec_pkg::*;
#(
  parameter int LVL_W       = DEF_LVL_W,
  parameter int SYNC_STAGES = DEF_STAGES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<LVL_W)-2:0]   irq_n,
  input  logic                    mask_load,
  input  logic [LVL_W-1:0]        mask_value,
  output logic [LVL_W-1:0]        cur_mask,
  output logic                    rec_valid,
  output logic [LVL_W-1:0]        rec_level,
  input  logic                    rec_ready
);
  localparam int NLVL = top_level(LVL_W);

  logic [NLVL-1:0] pend;
  logic            nmi_pend;
  logic            take;
  logic [LVL_W-1:0] mask_q;

  irq_sync #(.W(NLVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_n(irq_n), .pend(pend)
  );

  assign take = rec_valid & rec_ready;

  nmi_qual u_nmi (
    .clk(clk), .rst_n(rst_n), .line(pend[NLVL-1]),
    .clr(take && (rec_level == LVL_W'(NLVL))),
    .pend(nmi_pend)
  );

  prio_pick #(.LVL_W(LVL_W)) u_pick (
    .req(pend[NLVL-2:0]), .nmi(nmi_pend), .mask(mask_q),
    .valid(rec_valid), .level(rec_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (take)      mask_q <= rec_level;
    else if (mask_load) mask_q <= mask_value;
  end

  assign cur_mask = mask_q;
endmodule

// File: rtl/irq_rec_chk.sv
module irq_rec_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mask_load,
  input logic [LVL_W-1:0] mask_value,
  input logic [LVL_W-1:0] cur_mask,
  input logic             rec_valid,
  input logic [LVL_W-1:0] rec_level,
  input logic             rec_ready
);
  // R2
  mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_level != '1) |-> (rec_level > cur_mask));

  // R3
  level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_level != '0));

  // R8
  ack_raises_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready) |=> (cur_mask == $past(rec_level)));

  // R9
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_load && !(rec_valid && rec_ready)) |=> (cur_mask == $past(mask_value)));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_load && !(rec_valid && rec_ready)) |=> $stable(cur_mask));
endmodule

bind irq_recognizer irq_rec_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_load(mask_load), .mask_value(mask_value),
  .cur_mask(cur_mask), .rec_valid(rec_valid), .rec_level(rec_level),
  .rec_ready(rec_ready)
);

// File: tb/tb_irq_recognizer.sv
`timescale 1ns/100ps
module tb_irq_recognizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_n = '1;
  logic       mask_load = 1'b0;
  logic [2:0] mask_value = '0;
  logic [2:0] cur_mask;
  logic       rec_valid;
  logic [2:0] rec_level;
  logic       rec_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit      v;
    int      lvl;
    int      msk;
    string   tag;
  } exp_t;

  exp_t sb[$];
  event sample_ev;

  always #2.5 clk = ~clk;

  irq_recognizer dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .mask_load(mask_load),
    .mask_value(mask_value), .cur_mask(cur_mask), .rec_valid(rec_valid),
    .rec_level(rec_level), .rec_ready(rec_ready)
  );

  // monitor: pops one expected item per sample and compares with the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rec_valid !== e.v || int'(cur_mask) != e.msk ||
            (e.v && int'(rec_level) != e.lvl)) begin
          errors++;
          $display("FAIL %s: valid=%0b level=%0d mask=%0d expected valid=%0b level=%0d mask=%0d",
                   e.tag, rec_valid, rec_level, cur_mask, e.v, e.lvl, e.msk);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_now(input bit v, input int lvl, input int msk, input string tag);
    exp_t e;
    e.v = v; e.lvl = lvl; e.msk = msk; e.tag = tag;
    sb.push_back(e);
    -> sample_ev;
    #0.1;
  endtask

  task automatic set_mask(input int m);
    mask_load  = 1'b1;
    mask_value = 3'(m);
    cyc(1);
    mask_load = 1'b0;
  endtask

  task automatic accept();
    rec_ready = 1'b1;
    cyc(1);
    rec_ready = 1'b0;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    expect_now(0, 0, 7, "R1 reset state");

    irq_n[2] = 1'b0;                 // level 3
    cyc(4);
    expect_now(0, 0, 7, "R2 level 3 under mask 7");
    set_mask(2);
    expect_now(1, 3, 2, "R2 level 3 above mask 2");
    set_mask(3);
    expect_now(0, 0, 3, "R2 level 3 equal to mask");
    set_mask(0);
    expect_now(1, 3, 0, "R3 level 3 with mask 0");
    irq_n = '1; irq_n[0] = 1'b0;     // level 1 only
    cyc(4);
    expect_now(1, 1, 0, "R3 level 1 with mask 0");
    irq_n = '1;
    cyc(4);
    expect_now(0, 0, 0, "R11 all released");

    irq_n[4] = 1'b0;                 // level 5 latency
    cyc(1);
    expect_now(0, 0, 0, "R10 level 5 after one edge");
    cyc(1);
    expect_now(1, 5, 0, "R10 level 5 after two edges");
    irq_n = '1;
    cyc(4);

    irq_n[0] = 1'b0; irq_n[3] = 1'b0; irq_n[5] = 1'b0;
    cyc(4);
    expect_now(1, 6, 0, "R4 levels 1,4,6 pick 6");
    irq_n[5] = 1'b1;
    cyc(4);
    expect_now(1, 4, 0, "R11 fall back to level 4");
    accept();
    expect_now(0, 0, 4, "R8 accept level 4 raises mask");

    set_mask(0);
    expect_now(1, 4, 0, "R9 mask written to 0");
    mask_load = 1'b1; mask_value = 3'd2; rec_ready = 1'b1;
    cyc(1);
    mask_load = 1'b0; rec_ready = 1'b0;
    expect_now(0, 0, 4, "R9 accept wins over write");
    set_mask(1);
    expect_now(1, 4, 1, "R9 mask written to 1");
    irq_n = '1;
    cyc(4);
    expect_now(0, 0, 1, "R11 released again");

    set_mask(7);
    irq_n[5] = 1'b0;                 // level 6 under mask 7
    cyc(4);
    expect_now(0, 0, 7, "R2 level 6 under mask 7");
    irq_n = '1;
    cyc(4);

    irq_n[6] = 1'b0;                 // level 7 latency
    cyc(2);
    expect_now(0, 0, 7, "R10 level 7 after two edges");
    cyc(1);
    expect_now(1, 7, 7, "R5 level 7 under mask 7 (R10 third edge)");
    accept();
    expect_now(0, 0, 7, "R8 accept level 7");
    cyc(4);
    expect_now(0, 0, 7, "R6 level 7 held low not taken again");
    irq_n[6] = 1'b1;
    cyc(4);
    irq_n[6] = 1'b0;
    cyc(4);
    expect_now(1, 7, 7, "R6 new fall re-arms level 7");
    accept();
    irq_n[6] = 1'b1;
    cyc(4);
    irq_n[6] = 1'b0;
    cyc(1);
    irq_n[6] = 1'b1;
    cyc(6);
    expect_now(0, 0, 7, "R7 short level 7 glitch");

    cyc(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule